// File: doc/BRIEF.md
# Paddle Game Score Keeper

This block keeps the running score of a single-player paddle-and-ball game. Other logic detects the collisions and sends one-cycle strobes: one when the ball strikes the paddle and one when it strikes the bottom wall. A paddle strike adds a point. A bottom-wall strike takes a point away. If the ball reaches the bottom wall while the score is already zero, the game ends.

Once the game has ended, the score and the end flag stay frozen until a synchronous restart begins a fresh game. The score counter saturates at its top value and never wraps. The block has no display, collision or timing logic of its own.

Top module: `score_keeper`

## Requirements
- R1: While rst_ni is low, score_o reads 0 and game_over_o reads 0, with no clock edge needed.
- R2: A cycle with hit_i high, restart_i low and game_over_o low raises score_o by one at the next clock edge, unless R3 applies.
- R3: At the top value 2^SCORE_W-1 (255 by default), a further hit leaves score_o at that value rather than wrapping to 0.
- R4: A cycle with miss_i high, hit_i low, restart_i low, game_over_o low and score_o nonzero lowers score_o by one at the next edge.
- R5: A cycle with miss_i high, hit_i low, restart_i low, game_over_o low and score_o equal to 0 sets game_over_o to 1 at the next edge and leaves score_o at 0.
- R6: game_over_o is a registered level. Once it is set, it stays 1 and score_o holds its value across any hit_i or miss_i activity until a restart.
- R7: restart_i high at a clock edge makes score_o 0 and game_over_o 0 after that edge, whatever hit_i and miss_i do in the same cycle.
- R8: When hit_i and miss_i are both high in one cycle, only the hit counts: the score rises as in R2 or R3, and game_over_o stays 0 even when the score was 0.
- R9: An event input held high for N consecutive cycles counts as N separate events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous new-game request |
| hit_i | input | 1 | Paddle-strike strobe |
| miss_i | input | 1 | Bottom-wall strike strobe |
| score_o | output | SCORE_W | Current score, unsigned |
| game_over_o | output | 1 | High from the losing miss until restart |

## Verification
The bench builds the block with SCORE_W set to 4, so the saturation point at 15 is only a few hits away. It then sweeps every score from 0 to 15 against all eight combinations of hit, miss and restart. With this width the zero, middle and full boundaries are all reached in one short run. Separate sequences cover the frozen game-over state, held-high strobes and an asynchronous reset in mid-game.

// File: rtl/score_pkg.sv
package score_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_END  = 2'd3
  } act_e;
endpackage

// File: rtl/score_arb.sv
module score_arb
  import score_pkg::*;
(
  input  logic hit_i,
  input  logic miss_i,
  input  logic zero_i,
  input  logic over_i,
  output act_e act_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (!over_i) begin
      if (hit_i)       act_o = ACT_INC;  // hit wins over a simultaneous miss
      else if (miss_i) act_o = zero_i ? ACT_END : ACT_DEC;
    end
  end

  always_comb begin
    if (over_i) assert_frozen_R6: assert (act_o == ACT_NONE);
  end
endmodule

// File: rtl/score_ctr.sv
module score_ctr
  import score_pkg::*;
#(
  parameter int unsigned SCORE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  act_e               act_i,
  output logic [SCORE_W-1:0] score_o,
  output logic               zero_o
);
  localparam logic [SCORE_W-1:0] SCORE_MAX = {SCORE_W{1'b1}};

  logic [SCORE_W-1:0] score_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_q <= '0;
    end else if (clr_i) begin
      score_q <= '0;
    end else begin
      unique case (act_i)
        ACT_INC: if (score_q != SCORE_MAX) score_q <= score_q + 1'b1;
        ACT_DEC: if (score_q != '0)        score_q <= score_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign score_o = score_q;
  assign zero_o  = (score_q == '0);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && act_i == ACT_INC && score_o == SCORE_MAX) |=> score_o == SCORE_MAX);
  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && act_i == ACT_INC && score_o != SCORE_MAX) |=> score_o == $past(score_o) + 1'b1);
  assert_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && act_i == ACT_DEC) |=> score_o == $past(score_o) - 1'b1);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> score_o == '0);
endmodule

// File: rtl/score_keeper.sv
module score_keeper
  import score_pkg::*;
#(
  parameter int unsigned SCORE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               hit_i,
  input  logic               miss_i,
  output logic [SCORE_W-1:0] score_o,
  output logic               game_over_o
);
  act_e act;
  logic zero;
  logic over_q;

  score_arb u_arb (
    .hit_i  (hit_i),
    .miss_i (miss_i),
    .zero_i (zero),
    .over_i (over_q),
    .act_o  (act)
  );

  score_ctr #(.SCORE_W(SCORE_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart_i),
    .act_i   (act),
    .score_o (score_o),
    .zero_o  (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              over_q <= 1'b0;
    else if (restart_i)       over_q <= 1'b0;
    else if (act == ACT_END)  over_q <= 1'b1;
  end

  assign game_over_o = over_q;

  assert_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!game_over_o && !restart_i && miss_i && !hit_i && score_o == '0)
      |=> game_over_o && score_o == '0);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (game_over_o && !restart_i) |=> game_over_o && $stable(score_o));
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !game_over_o);
  assert_hit_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!game_over_o && !restart_i && hit_i && miss_i) |=> !game_over_o);
endmodule

// File: tb/sim_score_keeper.sv
`timescale 1ns/1ps
module sim_score_keeper;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic restart = 1'b0, hit = 1'b0, miss = 1'b0;
  logic [W-1:0] score;
  logic over;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  score_keeper #(.SCORE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart),
    .hit_i(hit), .miss_i(miss), .score_o(score), .game_over_o(over)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic h, input logic m, input logic r);
    hit = h; miss = m; restart = r;
    @(negedge clk);
    hit = 1'b0; miss = 1'b0; restart = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk("R1 score", int'(score), 0);
    chk("R1 over", int'(over), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // sweep all scores against all event combinations
    for (int s = 0; s <= MAX; s++) begin
      for (int c = 0; c < 8; c++) begin
        int es, eo;
        logic h, m, r;
        h = c[0]; m = c[1]; r = c[2];
        cyc(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < s; k++) cyc(1'b1, 1'b0, 1'b0);
        chk("R2 build", int'(score), s);
        if (r)      begin es = 0; eo = 0; end
        else if (h) begin es = (s == MAX) ? MAX : s + 1; eo = 0; end
        else if (m) begin es = (s == 0) ? 0 : s - 1; eo = (s == 0) ? 1 : 0; end
        else        begin es = s; eo = 0; end
        cyc(h, m, r);
        if (r)          chk("R7 score", int'(score), es);
        else if (h && m) chk("R8 score", int'(score), es);
        else if (h && s == MAX) chk("R3 sat", int'(score), es);
        else if (h)     chk("R2 inc", int'(score), es);
        else if (m && s == 0) chk("R5 score", int'(score), es);
        else if (m)     chk("R4 dec", int'(score), es);
        else            chk("R2 idle", int'(score), es);
        if (r)          chk("R7 over", int'(over), eo);
        else if (h && m) chk("R8 over", int'(over), eo);
        else if (m)     chk("R5 over", int'(over), eo);
        else            chk("R2 over", int'(over), eo);
      end
    end

    // held strobe
    cyc(1'b0, 1'b0, 1'b1);
    hit = 1'b1;
    repeat (5) @(negedge clk);
    hit = 1'b0;
    chk("R9 held hit", int'(score), 5);
    miss = 1'b1;
    repeat (3) @(negedge clk);
    miss = 1'b0;
    chk("R9 held miss", int'(score), 2);

    // frozen game over
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R5 end", int'(over), 1);
    hit = 1'b1;
    repeat (3) @(negedge clk);
    hit = 1'b0;
    chk("R6 hits ignored", int'(score), 0);
    chk("R6 over held", int'(over), 1);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R6 miss ignored", int'(score), 0);
    chk("R6 over held2", int'(over), 1);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R7 restart over", int'(over), 0);
    chk("R7 restart score", int'(score), 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R7 live again", int'(score), 1);

    // async reset mid-game
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async over", int'(over), 0);
    chk("R1 async score", int'(score), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule